// File: doc/BRIEF.md
# Neutral-Point Balancing Dwell Splitter

This block decides how the dwell time of one redundant small vector in a three-level clamped inverter is divided between its two switching states. One state of the pair connects the load to the neutral point from the positive half and pushes the midpoint voltage up. The other connects it from the negative half and pulls the midpoint down. Once per modulation period the block compares the two digitized capacitor voltages. When the lower capacitor exceeds the upper one by more than a programmable tolerance, or falls short of it by more than that tolerance, the block shifts dwell from one state to the other by a programmable fraction. The sequencer downstream receives the two counts and puts the pair into its pattern.

The direction of the shift depends on the power-flow mode. In inverting operation, a positive error lengthens the positive-side state. In converting operation the same error lengthens the negative-side state. A negative error reverses the choice in each mode. Inside the tolerance band the split is even. The correction fraction is a signed fixed-point value with 15 fraction bits. The product is rounded so that the two counts always add up exactly to the requested dwell. The results are registered on the period strobe and stay constant between strobes.

Top module: `np_dwell_balancer`

## Requirements
- R1: The error is vc2_i minus vc1_i. It is formed wide enough that every pair of full-scale signed inputs, including the most negative against the most positive, is classified correctly.
- R2: In inverting mode (conv_mode_i = 0), an error strictly greater than thr_i applies the correction +m, where m is the clamped magnitude. corr_o then reads 2'b01, meaning the P part is lengthened.
- R3: In converting mode (conv_mode_i = 1), an error strictly greater than thr_i applies −m, and corr_o reads 2'b10, meaning the N part is lengthened.
- R4: An error strictly less than −thr_i applies the opposite sign to the one in R2 or R3 for the same mode. This gives −m with corr_o = 2'b10 in inverting mode, and +m with corr_o = 2'b01 in converting mode.
- R5: When the error lies within −thr_i to +thr_i inclusive, the correction is zero and corr_o reads 2'b00. The P part is then ceil(ds/2).
- R6: With correction d in units of 2^-15, the P part is floor((ds·(32768+d) + 32768) / 65536). The N part is ds minus the P part, so the two always sum exactly to ds_i.
- R7: corr_mag_i is unsigned with 15 fraction bits. Any value above 32768 (1.0) is treated as exactly 1.0. With magnitude 1.0, one part receives the whole dwell and the other receives zero.
- R8: Outputs change only at a rising edge where strobe_i is high, and they become visible after that edge. At all other edges, including when the inputs change, the outputs hold their values.
- R9: While reset is asserted, and until the first strobe after reset, both dwell outputs are zero and corr_o is 2'b00. Reset assertion takes effect asynchronously, and its release is synchronized over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Modulation-period update strobe |
| vc1_i | input | VW | Upper capacitor voltage, signed |
| vc2_i | input | VW | Lower capacitor voltage, signed |
| thr_i | input | VW | Allowed deviation, unsigned |
| conv_mode_i | input | 1 | 0 = inverting, 1 = converting |
| corr_mag_i | input | FW+1 | Correction magnitude, unsigned, FW fraction bits |
| ds_i | input | DW | Total small-vector dwell count |
| p_dwell_o | output | DW | Dwell count for the P-type state |
| n_dwell_o | output | DW | Dwell count for the N-type state |
| corr_o | output | 2 | 00 none, 01 P lengthened, 10 N lengthened |

## Verification
The hardest situations to reach are the edges of the tolerance band and the full-scale corners of the subtraction. At the band edges an error exactly equal to ±thr_i must still give an even split. At the full-scale corners a narrow difference would wrap and flip the sign of the correction. The bench uses a reduced voltage width so that every pair of capacitor readings can be applied against several thresholds, including zero and the largest threshold, in both modes. A second sweep pairs every dwell count with magnitudes around the clamp point and at odd fractions, where rounding decides which part receives the extra count.

// File: rtl/np_bal_pkg.sv
package np_bal_pkg;

  typedef enum logic [1:0] {
    CORR_NONE  = 2'b00,
    CORR_PLONG = 2'b01,
    CORR_NLONG = 2'b10
  } corr_e;

  typedef enum logic [1:0] {
    ERR_INBAND = 2'b00,
    ERR_HIGH   = 2'b01,
    ERR_LOW    = 2'b10
  } err_cls_e;

endpackage

// File: rtl/np_err_class.sv
module np_err_class
  import np_bal_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic signed [VW-1:0] vc1_i,
  input  logic signed [VW-1:0] vc2_i,
  input  logic        [VW-1:0] thr_i,
  output err_cls_e             cls_o
);

  localparam int EW = VW + 2;

  logic signed [EW-1:0] diff;
  logic signed [EW-1:0] thr_pos;
  logic signed [EW-1:0] thr_neg;

  always_comb begin
    diff    = {{2{vc2_i[VW-1]}}, vc2_i} - {{2{vc1_i[VW-1]}}, vc1_i};
    thr_pos = {2'b00, thr_i};
    thr_neg = -thr_pos;
    if (diff > thr_pos) begin
      cls_o = ERR_HIGH;
    end else if (diff < thr_neg) begin
      cls_o = ERR_LOW;
    end else begin
      cls_o = ERR_INBAND;
    end
  end

endmodule

// File: rtl/np_corr_sel.sv
module np_corr_sel
  import np_bal_pkg::*;
#(
  parameter int FW = 15
) (
  input  err_cls_e             cls_i,
  input  logic                 conv_mode_i,
  input  logic        [FW:0]   mag_i,
  output logic signed [FW+1:0] dt_o,
  output corr_e                corr_o
);

  localparam logic [FW:0] ONE = {1'b1, {FW{1'b0}}};

  logic [FW:0] mag_c;
  logic        lengthen_p;

  always_comb begin
    mag_c      = (mag_i > ONE) ? ONE : mag_i;
    lengthen_p = ((cls_i == ERR_HIGH) && !conv_mode_i) ||
                 ((cls_i == ERR_LOW)  &&  conv_mode_i);
    if (cls_i == ERR_INBAND) begin
      dt_o   = '0;
      corr_o = CORR_NONE;
    end else if (lengthen_p) begin
      dt_o   = $signed({1'b0, mag_c});
      corr_o = CORR_PLONG;
    end else begin
      dt_o   = -$signed({1'b0, mag_c});
      corr_o = CORR_NLONG;
    end
  end

endmodule

// File: rtl/np_dwell_split.sv
module np_dwell_split #(
  parameter int DW = 10,
  parameter int FW = 15
) (
  input  logic        [DW-1:0] ds_i,
  input  logic signed [FW+1:0] dt_i,
  output logic        [DW-1:0] p_o,
  output logic        [DW-1:0] n_o
);

  localparam int PW = DW + FW + 3;

  logic signed [FW+2:0] fac_s;
  logic        [FW+1:0] fac;
  logic        [PW-1:0] prod;
  logic        [PW-1:0] rnd;
  logic        [PW-1:0] p_full;

  always_comb begin
    fac_s  = $signed({3'b001, {FW{1'b0}}}) + $signed({dt_i[FW+1], dt_i});
    fac    = fac_s[FW+1:0];
    prod   = PW'(ds_i) * PW'(fac);
    rnd    = prod + {{(PW-FW-1){1'b0}}, 1'b1, {FW{1'b0}}};
    p_full = rnd >> (FW + 1);
    p_o    = p_full[DW-1:0];
    n_o    = ds_i - p_o;
  end

  // R6
  always_comb begin
    if (!$isunknown({ds_i, dt_i})) begin
      split_range_chk: assert (p_o <= ds_i);
    end
  end

endmodule

// File: rtl/np_dwell_balancer.sv
module np_dwell_balancer
  import np_bal_pkg::*;
#(
  parameter int VW = 12,
  parameter int DW = 10,
  parameter int FW = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe_i,
  input  logic signed [VW-1:0] vc1_i,
  input  logic signed [VW-1:0] vc2_i,
  input  logic        [VW-1:0] thr_i,
  input  logic                 conv_mode_i,
  input  logic        [FW:0]   corr_mag_i,
  input  logic        [DW-1:0] ds_i,
  output logic        [DW-1:0] p_dwell_o,
  output logic        [DW-1:0] n_dwell_o,
  output logic        [1:0]    corr_o
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  err_cls_e            cls;
  logic signed [FW+1:0] dt;
  corr_e               corr_new;
  logic [DW-1:0]       p_new;
  logic [DW-1:0]       n_new;

  np_err_class #(.VW(VW)) u_cls (
    .vc1_i (vc1_i),
    .vc2_i (vc2_i),
    .thr_i (thr_i),
    .cls_o (cls)
  );

  np_corr_sel #(.FW(FW)) u_sel (
    .cls_i       (cls),
    .conv_mode_i (conv_mode_i),
    .mag_i       (corr_mag_i),
    .dt_o        (dt),
    .corr_o      (corr_new)
  );

  np_dwell_split #(.DW(DW), .FW(FW)) u_split (
    .ds_i (ds_i),
    .dt_i (dt),
    .p_o  (p_new),
    .n_o  (n_new)
  );

  logic [DW-1:0] p_q, p_d;
  logic [DW-1:0] n_q, n_d;
  corr_e         corr_q, corr_d;

  always_comb begin
    p_d    = p_q;
    n_d    = n_q;
    corr_d = corr_q;
    if (strobe_i) begin
      p_d    = p_new;
      n_d    = n_new;
      corr_d = corr_new;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      p_q    <= '0;
      n_q    <= '0;
      corr_q <= CORR_NONE;
    end else begin
      p_q    <= p_d;
      n_q    <= n_d;
      corr_q <= corr_d;
    end
  end

  assign p_dwell_o = p_q;
  assign n_dwell_o = n_q;
  assign corr_o    = corr_q;

  // R6
  sum_exact_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    strobe_i |=> ({1'b0, p_dwell_o} + {1'b0, n_dwell_o}) == {1'b0, $past(ds_i)});

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !strobe_i |=> $stable({p_dwell_o, n_dwell_o, corr_o}));

  // R5
  even_split_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (corr_o == 2'b00) |-> ((p_dwell_o == n_dwell_o) || (p_dwell_o == n_dwell_o + 1'b1)));

  // R2
  plong_order_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (corr_o == 2'b01) |-> (p_dwell_o >= n_dwell_o));

  // R4
  nlong_order_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (corr_o == 2'b10) |-> ({1'b0, n_dwell_o} + 1'b1 >= {1'b0, p_dwell_o}));

  // R3
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    corr_o != 2'b11);

endmodule

// File: tb/tb_np_dwell_balancer.sv
module tb_np_dwell_balancer;

  localparam int VW = 5;
  localparam int DW = 6;
  localparam int FW = 15;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 strobe_i;
  logic signed [VW-1:0] vc1_i;
  logic signed [VW-1:0] vc2_i;
  logic        [VW-1:0] thr_i;
  logic                 conv_mode_i;
  logic        [FW:0]   corr_mag_i;
  logic        [DW-1:0] ds_i;
  logic        [DW-1:0] p_dwell_o;
  logic        [DW-1:0] n_dwell_o;
  logic        [1:0]    corr_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  np_dwell_balancer #(.VW(VW), .DW(DW), .FW(FW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (strobe_i),
    .vc1_i       (vc1_i),
    .vc2_i       (vc2_i),
    .thr_i       (thr_i),
    .conv_mode_i (conv_mode_i),
    .corr_mag_i  (corr_mag_i),
    .ds_i        (ds_i),
    .p_dwell_o   (p_dwell_o),
    .n_dwell_o   (n_dwell_o),
    .corr_o      (corr_o)
  );

  task automatic check3(string req, int ep, int en, int ec);
    checks++;
    if (int'(p_dwell_o) != ep || int'(n_dwell_o) != en || int'(corr_o) != ec) begin
      fails++;
      $display("FAIL %s: p=%0d n=%0d corr=%0d expected p=%0d n=%0d corr=%0d",
               req, p_dwell_o, n_dwell_o, corr_o, ep, en, ec);
    end
  endtask

  task automatic expect_vals(int v1, int v2, int thr, int mode, int mag, int ds,
                             output int ep, output int en, output int ec);
    int err, m, dt;
    err = v2 - v1;
    m   = (mag > 32768) ? 32768 : mag;
    if (err > thr) begin
      dt = (mode == 0) ? m : -m;
    end else if (err < -thr) begin
      dt = (mode == 0) ? -m : m;
    end else begin
      dt = 0;
    end
    if (err > thr || err < -thr) begin
      ec = (((err > thr) ? 1 : 0) ^ mode) != 0 ? 1 : 2;
    end else begin
      ec = 0;
    end
    ep = (ds * (32768 + dt) + 32768) / 65536;
    en = ds - ep;
  endtask

  task automatic apply(string req, int v1, int v2, int thr, int mode, int mag, int ds);
    int ep, en, ec;
    @(negedge clk);
    vc1_i       = VW'(v1);
    vc2_i       = VW'(v2);
    thr_i       = VW'(thr);
    conv_mode_i = mode[0];
    corr_mag_i  = (FW+1)'(mag);
    ds_i        = DW'(ds);
    strobe_i    = 1'b1;
    @(negedge clk);
    strobe_i    = 1'b0;
    expect_vals(v1, v2, thr, mode, mag, ds, ep, en, ec);
    check3(req, ep, en, ec);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int ep, en, ec;
    int mags[7] = '{0, 1, 8192, 16383, 32767, 32768, 65535};
    rst_n = 1'b0; strobe_i = 1'b0; vc1_i = '0; vc2_i = '0; thr_i = '0;
    conv_mode_i = 1'b0; corr_mag_i = '0; ds_i = '0;
    repeat (3) @(negedge clk);
    strobe_i = 1'b1; vc2_i = 5'sd10; ds_i = 6'd40; corr_mag_i = 16'd16384;
    @(negedge clk);
    // R9: reset holds outputs even with a strobe present
    check3("R9", 0, 0, 0);
    strobe_i = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check3("R9", 0, 0, 0);

    // R1 R2 R3 R4 R5: every voltage pair, several thresholds, both modes
    for (int mode = 0; mode < 2; mode++) begin
      for (int ti = 0; ti < 3; ti++) begin
        for (int v1 = -16; v1 < 16; v1++) begin
          for (int v2 = -16; v2 < 16; v2++) begin
            int thr;
            thr = (ti == 0) ? 0 : ((ti == 1) ? 3 : 31);
            apply("R1/R2/R3/R4/R5", v1, v2, thr, mode, 12288, (v1 + v2 + 40) & 63);
          end
        end
      end
    end

    // R6 R7: every dwell count against magnitudes around the clamp
    for (int ds = 0; ds < 64; ds++) begin
      for (int mi = 0; mi < 7; mi++) begin
        for (int mode = 0; mode < 2; mode++) begin
          apply("R6/R7", 0, 9, 4, mode, mags[mi], ds);
          apply("R6/R7", 9, 0, 4, mode, mags[mi], ds);
          apply("R6", 2, 0, 4, mode, mags[mi], ds);
        end
      end
    end

    // R7: full clamp moves the whole dwell
    apply("R7", -16, 15, 0, 0, 65535, 63);
    check3("R7", 63, 0, 1);

    // R8: inputs move without a strobe, outputs hold
    apply("R8", 0, 10, 2, 1, 32768, 50);
    expect_vals(0, 10, 2, 1, 32768, 50, ep, en, ec);
    @(negedge clk);
    vc1_i = 5'sd12; vc2_i = -5'sd12; ds_i = 6'd7; conv_mode_i = 1'b0;
    corr_mag_i = 16'd100;
    repeat (3) @(negedge clk);
    check3("R8", ep, en, ec);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule